// File: doc/BRIEF.md
# Multi-Channel Low-Power Down-Counting Timer

This block is a bank of independent 32-bit down-counting timers that run from a slow low-power clock. Software picks, per timer, whether the counter steps on every clock cycle (edge-count mode) or on a time base tick (microsecond mode). In microsecond mode a divider built from an integer part and an 8-bit fraction turns an arbitrary clock into an average 1 µs tick. An optional 8-bit prescaler stretches that tick to 256 µs.

Each timer counts down from a programmed start value. When it reaches zero it sets a sticky flag, and it drives its own interrupt line when the interrupt is enabled. It then either stops by itself (one-shot) or reloads and carries on (periodic). A plain word-addressed read/write port holds, for each channel, a start value register at word `2*i` and a control register at word `2*i+1`. A shared flag register sits at word `2*NUM_CH`.

Control register fields: bit 0 run, bit 1 microsecond mode, bit 2 periodic, bit 3 interrupt enable, bit 4 coarse (256-tick) resolution, bits 15:8 fraction, bits 31:16 integer divide.

Top module: `lpt_bank`

## Requirements
- R1: After reset every register reads 0, the flag register is 0 and every interrupt output is low.
- R2: In edge-count mode, a timer started with start value N reaches zero and sets its flag on the (N+1)-th clock edge after the edge that wrote its control register with bit 0 set.
- R3: In microsecond mode, each base tick lasts I cycles (I = control bits 31:16, with 0 treated as 1), plus one extra cycle whenever the previous tick's 8-bit fraction accumulation (control bits 15:8, starting from 0) carried out; the counter steps once per tick.
- R4: With control bit 4 set in microsecond mode, the counter steps once every 256 base ticks.
- R5: A one-shot timer (bit 2 clear) stops on reaching zero and its control register then reads bit 0 as 0.
- R6: A periodic timer reloads its start value on the count step after reaching zero, so it raises its flag every N+1 count steps; a start value of 0 raises the flag on every count step.
- R7: Flag i is bit i of the flag register and stays set until software writes 1 to that bit; writing 0 has no effect, and an expiry in the same cycle as a clear leaves the flag set.
- R8: Interrupt output i is high exactly while flag i is set and bit 3 of that timer's control register is set.
- R9: Writing the control register with bit 0 set restarts the timer from the current start value, even if it is running; writing it with bit 0 clear stops it.
- R10: Each timer runs independently: starting or expiring one timer does not change another timer's flag, count or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-power timer clock; edge-count mode counts its rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one clock cycle |
| bus_addr | input | ADDR_W | Word address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | One interrupt line per timer |

## Verification
The assertions watch the per-cycle consequences of the internal events on every cycle. An expiry must set the flag. A set flag holds unless it is cleared. One-shot expiry drops the run state, while periodic expiry keeps it. A start or stop write takes effect on the next edge, and no interrupt appears without its flag. What the assertions cannot see is elapsed time: the exact edge of expiry for a given start value, the fractional stretch pattern of the divider, the 256-tick prescale, and restart from a new value. The bench's directed scenarios measure these in clock edges against a model of its own.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int LPT_INT_W  = 16;
  localparam int LPT_FRAC_W = 8;
  localparam int LPT_PRE_W  = 8;
  localparam int LPT_REG_W  = 32;

  typedef struct packed {
    logic [LPT_INT_W-1:0]  int_part;
    logic [LPT_FRAC_W-1:0] frac;
    logic                  coarse;
    logic                  irq_en;
    logic                  periodic;
    logic                  usec;
  } lpt_cfg_t;

  // Last divider count of a tick: max(I,1) - 1, plus one when stretched.
  function automatic logic [LPT_INT_W:0] lpt_div_limit(
    input logic [LPT_INT_W-1:0] ip,
    input logic                 stretch
  );
    logic [LPT_INT_W:0] base;
    base = (ip == '0) ? (LPT_INT_W+1)'(1) : {1'b0, ip};
    return base - (LPT_INT_W+1)'(1) + {{LPT_INT_W{1'b0}}, stretch};
  endfunction

  // Phase accumulator step: {carry, new phase}.
  function automatic logic [LPT_FRAC_W:0] lpt_frac_step(
    input logic [LPT_FRAC_W-1:0] phase,
    input logic [LPT_FRAC_W-1:0] fr
  );
    return {1'b0, phase} + {1'b0, fr};
  endfunction

  function automatic lpt_cfg_t lpt_ctrl_unpack(input logic [LPT_REG_W-1:0] w);
    lpt_cfg_t c;
    c.int_part = w[31:16];
    c.frac     = w[15:8];
    c.coarse   = w[4];
    c.irq_en   = w[3];
    c.periodic = w[2];
    c.usec     = w[1];
    return c;
  endfunction

  function automatic logic [LPT_REG_W-1:0] lpt_ctrl_pack(
    input lpt_cfg_t c,
    input logic     run
  );
    return {c.int_part, c.frac, 3'b000, c.coarse, c.irq_en, c.periodic, c.usec, run};
  endfunction

endpackage

// File: rtl/lpt_tick_gen.sv
module lpt_tick_gen
  import lpt_pkg::*;
#(
  parameter int PRE_W = LPT_PRE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  enable,
  input  logic [LPT_INT_W-1:0]  int_part,
  input  logic [LPT_FRAC_W-1:0] frac,
  input  logic                  coarse,
  output logic                  base_tick,
  output logic                  tick
);

  logic [LPT_INT_W:0]    div_q;
  logic [LPT_FRAC_W-1:0] phase_q;
  logic                  stretch_q;
  logic [PRE_W-1:0]      pre_q;
  logic [LPT_INT_W:0]    div_last;
  logic [LPT_FRAC_W:0]   phase_nxt;

  assign div_last  = lpt_div_limit(int_part, stretch_q);
  assign phase_nxt = lpt_frac_step(phase_q, frac);
  assign base_tick = enable && (div_q == div_last);
  assign tick      = coarse ? (base_tick && (pre_q == {PRE_W{1'b1}})) : base_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      phase_q   <= '0;
      stretch_q <= 1'b0;
      pre_q     <= '0;
    end else if (restart) begin
      div_q     <= '0;
      phase_q   <= '0;
      stretch_q <= 1'b0;
      pre_q     <= '0;
    end else if (enable) begin
      if (base_tick) begin
        div_q     <= '0;
        phase_q   <= phase_nxt[LPT_FRAC_W-1:0];
        stretch_q <= phase_nxt[LPT_FRAC_W];
        pre_q     <= pre_q + PRE_W'(1);
      end else begin
        div_q <= div_q + (LPT_INT_W+1)'(1);
      end
    end
  end

endmodule

// File: rtl/lpt_channel.sv
module lpt_channel
  import lpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             flag_clr,
  input  lpt_cfg_t         cfg,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic             expire,
  output logic             flag
);

  logic             run_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tb_base;
  logic             tb_tick;
  logic             count_en;

  lpt_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start),
    .enable    (run_q && cfg.usec),
    .int_part  (cfg.int_part),
    .frac      (cfg.frac),
    .coarse    (cfg.coarse),
    .base_tick (tb_base),
    .tick      (tb_tick)
  );

  assign count_en = run_q && (cfg.usec ? tb_tick : 1'b1);
  assign expire   = count_en && (cnt_q == '0);
  assign running  = run_q;
  assign flag     = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= load_val;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (count_en) begin
      if (cnt_q == '0) begin
        if (cfg.periodic) cnt_q <= load_val;
        else              run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/lpt_bank.sv
module lpt_bank
  import lpt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  localparam int ADDR_W = $clog2(2*NUM_CH+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [LPT_REG_W-1:0] bus_wdata,
  output logic [LPT_REG_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0]    irq
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2*NUM_CH);

  lpt_cfg_t         cfg_q  [NUM_CH];
  logic [CNT_W-1:0] load_q [NUM_CH];

  logic [NUM_CH-1:0] start_v;
  logic [NUM_CH-1:0] stop_v;
  logic [NUM_CH-1:0] clr_v;
  logic [NUM_CH-1:0] expire_v;
  logic [NUM_CH-1:0] running_v;
  logic [NUM_CH-1:0] flag_v;
  logic [NUM_CH-1:0] periodic_v;
  logic [NUM_CH-1:0] irq_en_v;
  logic              wr_stat;

  assign wr_stat = bus_wr && (bus_addr == STAT_ADDR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr_load;
    logic wr_ctrl;

    assign wr_load       = bus_wr && (bus_addr == ADDR_W'(2*i));
    assign wr_ctrl       = bus_wr && (bus_addr == ADDR_W'(2*i+1));
    assign start_v[i]    = wr_ctrl && bus_wdata[0];
    assign stop_v[i]     = wr_ctrl && !bus_wdata[0];
    assign clr_v[i]      = wr_stat && bus_wdata[i];
    assign periodic_v[i] = cfg_q[i].periodic;
    assign irq_en_v[i]   = cfg_q[i].irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i]  <= '0;
        load_q[i] <= '0;
      end else begin
        if (wr_ctrl) cfg_q[i]  <= lpt_ctrl_unpack(bus_wdata);
        if (wr_load) load_q[i] <= bus_wdata[CNT_W-1:0];
      end
    end

    lpt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_v[i]),
      .stop     (stop_v[i]),
      .flag_clr (clr_v[i]),
      .cfg      (cfg_q[i]),
      .load_val (load_q[i]),
      .running  (running_v[i]),
      .expire   (expire_v[i]),
      .flag     (flag_v[i])
    );
  end

  assign irq = flag_v & irq_en_v;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(2*i))   bus_rdata = LPT_REG_W'(load_q[i]);
      if (bus_addr == ADDR_W'(2*i+1)) bus_rdata = lpt_ctrl_pack(cfg_q[i], running_v[i]);
    end
    if (bus_addr == STAT_ADDR) bus_rdata = LPT_REG_W'(flag_v);
  end

endmodule

// File: rtl/lpt_bank_chk.sv
module lpt_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] start_v,
  input logic [NUM_CH-1:0] stop_v,
  input logic [NUM_CH-1:0] clr_v,
  input logic [NUM_CH-1:0] expire_v,
  input logic [NUM_CH-1:0] running_v,
  input logic [NUM_CH-1:0] flag_v,
  input logic [NUM_CH-1:0] periodic_v,
  input logic [NUM_CH-1:0] irq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r7_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[i] |=> flag_v[i]);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_v[i] && !clr_v[i] |=> flag_v[i]);

    a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[i] && !periodic_v[i] && !start_v[i] |=> !running_v[i]);

    a_r6_periodic_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[i] && periodic_v[i] && !stop_v[i] |=> running_v[i]);

    a_r9_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      start_v[i] |=> running_v[i]);

    a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
      stop_v[i] |=> !running_v[i]);

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag_v[i]);
  end

endmodule

bind lpt_bank lpt_bank_chk #(.NUM_CH(NUM_CH)) u_lpt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_v    (start_v),
  .stop_v     (stop_v),
  .clr_v      (clr_v),
  .expire_v   (expire_v),
  .running_v  (running_v),
  .flag_v     (flag_v),
  .periodic_v (periodic_v),
  .irq        (irq)
);

// File: tb/test_lpt_bank.sv
module test_lpt_bank;

  localparam int NCH  = 4;
  localparam int AW   = $clog2(2*NCH+1);
  localparam logic [AW-1:0] STAT = AW'(2*NCH);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpt_bank i_lpt_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Control word: int[31:16] frac[15:8] coarse[4] irq_en[3] periodic[2] usec[1] run[0]
  function automatic logic [31:0] ctrl_word(input bit run, input bit usec, input bit per,
                                            input bit ie, input bit coarse,
                                            input int fr, input int ip);
    return {ip[15:0], fr[7:0], 3'b000, coarse, ie, per, usec, run};
  endfunction

  // Clock cycles to cover n base ticks with integer ip and fraction fr.
  function automatic int tick_cycles(input int ip, input int fr, input int n);
    int acc = 0;
    int tot = 0;
    int extra = 0;
    int base = (ip == 0) ? 1 : ip;
    for (int k = 0; k < n; k++) begin
      tot += base + extra;
      acc += fr;
      extra = (acc >= 256) ? 1 : 0;
      acc = acc % 256;
    end
    return tot;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Write lands on the next rising edge; returns at the falling edge after it.
  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_to_irq(input int ch, input int lim, output int n);
    n = 0;
    while (!irq[ch] && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(STAT, d);        check("R1", "flags after reset", d, 0);
    check("R1", "irq after reset", 32'(irq), 0);
    bus_read(AW'(1), d);      check("R1", "ctrl0 after reset", d, 0);
    bus_read(AW'(6), d);      check("R1", "load3 after reset", d, 0);
  endtask

  task automatic t_oneshot_count;
    logic [31:0] d;
    bus_write(AW'(0), 32'd5);
    bus_write(AW'(1), ctrl_word(1, 0, 0, 1, 0, 0, 0));
    wait_edges(5);
    bus_read(STAT, d);        check("R2", "flag before N+1 edges", d, 0);
    check("R8", "irq before expiry", 32'(irq[0]), 0);
    wait_edges(1);
    bus_read(STAT, d);        check("R2", "flag at N+1 edges", d, 32'h1);
    check("R8", "irq with enable", 32'(irq[0]), 1);
    bus_read(AW'(1), d);      check("R5", "run bit after one-shot", 32'(d[0]), 0);
    wait_edges(20);
    bus_read(STAT, d);        check("R7", "flag held", d, 32'h1);
    bus_write(STAT, 32'h0);
    bus_read(STAT, d);        check("R7", "write 0 keeps flag", d, 32'h1);
    bus_write(STAT, 32'h1);
    bus_read(STAT, d);        check("R7", "write 1 clears flag", d, 0);
    check("R8", "irq drops with flag", 32'(irq[0]), 0);
    wait_edges(20);
    bus_read(STAT, d);        check("R5", "stopped timer silent", d, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    bus_write(AW'(2), 32'd2);
    bus_write(AW'(3), ctrl_word(1, 0, 1, 0, 0, 0, 0));
    wait_edges(3);
    bus_read(STAT, d);        check("R6", "first periodic expiry", d, 32'h2);
    check("R8", "irq off when disabled", 32'(irq), 0);
    bus_write(STAT, 32'h2);   // clear at edge 5
    bus_read(STAT, d);        check("R6", "cleared between expiries", d, 0);
    wait_edges(1);
    bus_read(STAT, d);        check("R6", "second expiry after reload", d, 32'h2);
    bus_read(AW'(3), d);      check("R6", "still running", 32'(d[0]), 1);
    bus_write(AW'(3), ctrl_word(0, 0, 1, 0, 0, 0, 0));
    bus_write(STAT, 32'h2);
    bus_read(AW'(3), d);      check("R9", "stop clears run", 32'(d[0]), 0);
    wait_edges(10);
    bus_read(STAT, d);        check("R9", "no expiry after stop", d, 0);
  endtask

  task automatic t_periodic_zero;
    logic [31:0] d;
    bus_write(AW'(4), 32'd0);
    bus_write(AW'(5), ctrl_word(1, 0, 1, 1, 0, 0, 0));
    bus_read(STAT, d);        check("R6", "zero load: none at start edge", d, 0);
    wait_edges(1);
    bus_read(STAT, d);        check("R6", "zero load: flag on first step", d, 32'h4);
    bus_write(STAT, 32'h4);   // lands with another expiry
    bus_read(STAT, d);        check("R7", "expiry beats clear", d, 32'h4);
    bus_write(AW'(5), ctrl_word(0, 0, 1, 1, 0, 0, 0));
    bus_write(STAT, 32'h4);
    wait_edges(3);
    bus_read(STAT, d);        check("R6", "zero load stopped and cleared", d, 0);
  endtask

  task automatic t_usec;
    int n;
    bus_write(AW'(2), 32'd3);
    bus_write(AW'(3), ctrl_word(1, 1, 0, 1, 0, 128, 3));
    edges_to_irq(1, 5000, n);
    check("R3", "I=3 F=128 N=3 edges", n, tick_cycles(3, 128, 4));
    bus_write(STAT, 32'h2);
    bus_write(AW'(2), 32'd6);
    bus_write(AW'(3), ctrl_word(1, 1, 0, 1, 0, 64, 5));
    edges_to_irq(1, 5000, n);
    check("R3", "I=5 F=64 N=6 edges", n, tick_cycles(5, 64, 7));
    bus_write(STAT, 32'h2);
    bus_write(AW'(2), 32'd4);
    bus_write(AW'(3), ctrl_word(1, 1, 0, 1, 0, 0, 0));
    edges_to_irq(1, 5000, n);
    check("R3", "I=0 acts as 1", n, 5);
    bus_write(STAT, 32'h2);
  endtask

  task automatic t_coarse;
    int n;
    bus_write(AW'(4), 32'd1);
    bus_write(AW'(5), ctrl_word(1, 1, 0, 1, 1, 0, 1));
    edges_to_irq(2, 5000, n);
    check("R4", "coarse I=1 N=1 edges", n, 512);
    bus_write(STAT, 32'h4);
    bus_write(AW'(4), 32'd0);
    bus_write(AW'(5), ctrl_word(1, 1, 0, 1, 1, 128, 1));
    edges_to_irq(2, 5000, n);
    check("R4", "coarse I=1 F=128 N=0 edges", n, tick_cycles(1, 128, 256));
    bus_write(STAT, 32'h4);
  endtask

  task automatic t_restart;
    int n;
    bus_write(AW'(0), 32'd10);
    bus_write(AW'(1), ctrl_word(1, 0, 0, 1, 0, 0, 0));
    wait_edges(3);
    bus_write(AW'(0), 32'd2);
    bus_write(AW'(1), ctrl_word(1, 0, 0, 1, 0, 0, 0));
    edges_to_irq(0, 100, n);
    check("R9", "restart from new start value", n, 3);
    bus_write(STAT, 32'h1);
  endtask

  task automatic t_independent;
    int n;
    logic [31:0] d;
    bus_write(AW'(6), 32'd8);
    bus_write(AW'(0), 32'd2);
    bus_write(AW'(7), ctrl_word(1, 0, 0, 1, 0, 0, 0));  // ch3 at edge X
    bus_write(AW'(1), ctrl_word(1, 0, 0, 1, 0, 0, 0));  // ch0 at edge X+2
    edges_to_irq(0, 100, n);
    check("R10", "ch0 timing beside ch3", n, 3);
    bus_read(STAT, d);        check("R10", "only ch0 flagged", d, 32'h1);
    check("R10", "only irq0 high", 32'(irq), 32'h1);
    edges_to_irq(3, 100, n);
    check("R10", "ch3 keeps own timing", n, 4);
    bus_read(STAT, d);        check("R10", "both flagged", d, 32'h9);
    bus_write(STAT, 32'h9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot_count();
    t_periodic();
    t_periodic_zero();
    t_usec();
    t_coarse();
    t_restart();
    t_independent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule